// File: doc/BRIEF.md
# Byte-Stream NAL Unit Delimiter

This block takes an H.264 elementary stream that uses start-code framing. The stream arrives one byte per cycle over a valid/ready handshake. The block finds each start code and treats the byte after it as the one-byte unit header. It then forwards the unit's bytes on an output stream that also uses valid/ready. Each output beat carries the header's type and reference-priority fields, a running byte count, and flags that mark the first and the last byte of the unit. On the last beat the count is the unit's full length, header byte included.

A unit is closed in one of two ways. The first is when a further start code is detected. The zero bytes of that start code are held back, so they never show up as payload and are never counted. The second is when the producer marks a byte as the final one in the stream. Zero bytes that do not end up forming a start code are released as ordinary payload, in their original order. Slice kind (I, P or B) is not reported, because the header byte does not carry it. Emulation-prevention bytes pass through unchanged.

Top module: `nal_delimiter`

## Requirements
- R1: A start code is two or more 0x00 bytes followed by 0x01. The byte after it is sent out as the first beat of a new unit, with `outSou` high. All zeros of the start code, however many, are dropped.
- R2: On every beat of a unit, `outType` equals bits 4:0 of its header byte and `outRef` equals bits 6:5.
- R3: A header with bit 7 set raises `hdrErr`. The flag stays high until reset, and the unit is still framed and forwarded normally.
- R4: `outLen` on each beat counts the unit's bytes up to and including that beat, header byte included. Zeros that belong to the next start code are never counted.
- R5: A zero run that is not followed by 0x01, and a single zero followed by 0x01, are forwarded as payload in their original order.
- R6: Bytes that arrive before the first start code, or after end of stream and before the next start code, produce no output.
- R7: When a byte with `inLast` high is accepted, the current unit closes. Its final byte, including any trailing zeros, carries `outEou`.
- R8: `outLen` is LEN_W bits wide (24 by default). It saturates at its maximum value instead of wrapping.
- R9: While `outValid` is high and `outReady` is low, every output stays stable. No input byte is lost or duplicated under any `outReady` pattern.
- R10: After reset, `outValid` and `hdrErr` are low and `inReady` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inData | input | 8 | Stream byte |
| inValid | input | 1 | Input byte valid |
| inLast | input | 1 | Marks the final byte of the stream |
| inReady | output | 1 | Block can accept a byte |
| outData | output | 8 | Unit byte (header or payload) |
| outValid | output | 1 | Output beat valid |
| outReady | input | 1 | Consumer accepts beat |
| outSou | output | 1 | Beat is the header byte of a unit |
| outEou | output | 1 | Beat is the last byte of a unit |
| outType | output | 5 | Unit type from header bits 4:0 |
| outRef | output | 2 | Reference priority from header bits 6:5 |
| outLen | output | LEN_W | Unit byte count through this beat |
| hdrErr | output | 1 | Sticky flag: a header had bit 7 set |

## Verification
The assertions check several properties on every cycle. Output beats must hold steady while stalled. Each unit must open at a count of one, and the count must then step by one or stay pinned at saturation. The header fields must match the header byte on the first beat, and the error flag must stay set once raised. Other behaviour can only be shown by the bench's scenarios, which compare the exact byte sequence against hand-derived expectations. That includes finding start codes with different numbers of leading zeros, releasing zeros that turn out to be payload, and discarding bytes before the first start code. It also includes closing a unit on end of stream with trailing zeros, and checking that no byte is lost under an irregular `outReady` pattern.

// File: rtl/nal_pkg.sv
package nal_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_HDR,
    ST_UNIT,
    ST_REL,
    ST_FIN
  } nal_state_e;

  typedef struct packed {
    logic zcInc;
    logic zcDec;
    logic zcClr;
    logic hdrLoad;
    logic pendFromIn;
    logic pendFromHeld;
    logic pendZero;
    logic heldLoad;
    logic emit;
    logic emitEou;
  } nal_strobe_t;

endpackage

// File: rtl/nal_ctrl.sv
module nal_ctrl
  import nal_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inLast,
  input  logic        isZero,
  input  logic        isOne,
  input  logic        zcZero,
  input  logic        zcGe2,
  input  logic        canEmit,
  output logic        inReady,
  output nal_strobe_t stb
);

  nal_state_e st, nxt;
  logic heldLast, heldLastNxt;
  logic acc;

  assign acc = inValid && inReady;

  always_comb begin
    stb         = '0;
    nxt         = st;
    heldLastNxt = heldLast;
    inReady     = 1'b0;
    unique case (st)
      ST_HUNT: begin
        inReady = 1'b1;
        if (acc) begin
          // leading garbage is dropped; only the zero run is tracked
          if (isOne && zcGe2) begin
            stb.zcClr = 1'b1;
            if (!inLast) nxt = ST_HDR;
          end else if (isZero && !inLast) begin
            stb.zcInc = 1'b1;
          end else begin
            stb.zcClr = 1'b1;
          end
        end
      end
      ST_HDR: begin
        inReady = 1'b1;
        if (acc) begin
          stb.hdrLoad    = 1'b1;
          stb.pendFromIn = 1'b1;
          nxt = inLast ? ST_FIN : ST_UNIT;
        end
      end
      ST_UNIT: begin
        inReady = canEmit;
        if (acc) begin
          if (isOne && zcGe2) begin
            stb.emit    = 1'b1;
            stb.emitEou = 1'b1;
            stb.zcClr   = 1'b1;
            nxt = inLast ? ST_HUNT : ST_HDR;
          end else if (isZero && inLast) begin
            stb.heldLoad = 1'b1;
            heldLastNxt  = 1'b1;
            nxt = ST_REL;
          end else if (isZero) begin
            stb.zcInc = 1'b1;
          end else if (!zcZero) begin
            stb.heldLoad = 1'b1;
            heldLastNxt  = inLast;
            nxt = ST_REL;
          end else begin
            stb.emit       = 1'b1;
            stb.pendFromIn = 1'b1;
            if (inLast) nxt = ST_FIN;
          end
        end
      end
      ST_REL: begin
        if (canEmit) begin
          stb.emit = 1'b1;
          if (!zcZero) begin
            stb.zcDec    = 1'b1;
            stb.pendZero = 1'b1;
          end else begin
            stb.pendFromHeld = 1'b1;
            nxt = heldLast ? ST_FIN : ST_UNIT;
          end
        end
      end
      ST_FIN: begin
        if (canEmit) begin
          stb.emit    = 1'b1;
          stb.emitEou = 1'b1;
          nxt = ST_HUNT;
        end
      end
      default: nxt = ST_HUNT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_HUNT;
      heldLast <= 1'b0;
    end else begin
      st       <= nxt;
      heldLast <= heldLastNxt;
    end
  end

endmodule

// File: rtl/nal_dp.sv
module nal_dp
  import nal_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int ZC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  nal_strobe_t      stb,
  input  logic [7:0]       inData,
  input  logic             outReady,
  output logic             isZero,
  output logic             isOne,
  output logic             zcZero,
  output logic             zcGe2,
  output logic             canEmit,
  output logic [7:0]       outData,
  output logic             outValid,
  output logic             outSou,
  output logic             outEou,
  output logic [4:0]       outType,
  output logic [1:0]       outRef,
  output logic [LEN_W-1:0] outLen,
  output logic             hdrErr
);

  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};
  localparam logic [ZC_W-1:0]  ZC_MAX  = {ZC_W{1'b1}};

  logic [7:0]       pend, held;
  logic [ZC_W-1:0]  zc;
  logic [LEN_W-1:0] cnt, nextLen;
  logic [4:0]       hdrType;
  logic [1:0]       hdrRef;
  logic             first;

  assign isZero  = (inData == 8'h00);
  assign isOne   = (inData == 8'h01);
  assign zcZero  = (zc == '0);
  assign zcGe2   = (zc >= ZC_W'(2));
  assign canEmit = !outValid || outReady;
  assign nextLen = (cnt == LEN_MAX) ? LEN_MAX : cnt + LEN_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend     <= '0;
      held     <= '0;
      zc       <= '0;
      cnt      <= '0;
      hdrType  <= '0;
      hdrRef   <= '0;
      first    <= 1'b0;
      hdrErr   <= 1'b0;
      outValid <= 1'b0;
      outData  <= '0;
      outSou   <= 1'b0;
      outEou   <= 1'b0;
      outType  <= '0;
      outRef   <= '0;
      outLen   <= '0;
    end else begin
      if (stb.zcClr)                      zc <= '0;
      else if (stb.zcInc && zc != ZC_MAX) zc <= zc + ZC_W'(1);
      else if (stb.zcDec)                 zc <= zc - ZC_W'(1);

      if (stb.heldLoad) held <= inData;

      if (stb.hdrLoad) begin
        hdrType <= inData[4:0];
        hdrRef  <= inData[6:5];
        first   <= 1'b1;
        cnt     <= '0;
        if (inData[7]) hdrErr <= 1'b1;
      end

      if (stb.pendFromIn)        pend <= inData;
      else if (stb.pendFromHeld) pend <= held;
      else if (stb.pendZero)     pend <= 8'h00;

      if (stb.emit) begin
        outValid <= 1'b1;
        outData  <= pend;
        outSou   <= first;
        outEou   <= stb.emitEou;
        outLen   <= nextLen;
        outType  <= hdrType;
        outRef   <= hdrRef;
        first    <= 1'b0;
        cnt      <= stb.emitEou ? '0 : nextLen;
      end else if (outReady) begin
        outValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/nal_delimiter.sv
module nal_delimiter
  import nal_pkg::*;
#(
  parameter int LEN_W = 24,
  parameter int ZC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       inData,
  input  logic             inValid,
  input  logic             inLast,
  output logic             inReady,
  output logic [7:0]       outData,
  output logic             outValid,
  input  logic             outReady,
  output logic             outSou,
  output logic             outEou,
  output logic [4:0]       outType,
  output logic [1:0]       outRef,
  output logic [LEN_W-1:0] outLen,
  output logic             hdrErr
);

  nal_strobe_t stb;
  logic isZero, isOne, zcZero, zcGe2, canEmit;

  nal_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .inLast  (inLast),
    .isZero  (isZero),
    .isOne   (isOne),
    .zcZero  (zcZero),
    .zcGe2   (zcGe2),
    .canEmit (canEmit),
    .inReady (inReady),
    .stb     (stb)
  );

  nal_dp #(.LEN_W(LEN_W), .ZC_W(ZC_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .stb      (stb),
    .inData   (inData),
    .outReady (outReady),
    .isZero   (isZero),
    .isOne    (isOne),
    .zcZero   (zcZero),
    .zcGe2    (zcGe2),
    .canEmit  (canEmit),
    .outData  (outData),
    .outValid (outValid),
    .outSou   (outSou),
    .outEou   (outEou),
    .outType  (outType),
    .outRef   (outRef),
    .outLen   (outLen),
    .hdrErr   (hdrErr)
  );

endmodule

// File: rtl/nal_delimiter_chk.sv
module nal_delimiter_chk #(
  parameter int LEN_W = 24
) (
  input logic             clk,
  input logic             rst,
  input logic [7:0]       outData,
  input logic             outValid,
  input logic             outReady,
  input logic             outSou,
  input logic             outEou,
  input logic [4:0]       outType,
  input logic [1:0]       outRef,
  input logic [LEN_W-1:0] outLen,
  input logic             hdrErr
);

  localparam logic [LEN_W-1:0] MAXL = {LEN_W{1'b1}};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outData) && $stable(outLen) && $stable(outEou) && $stable(outSou)); // R9

  AST_SOU_LEN_ONE: assert property (@(posedge clk) disable iff (rst)
    outValid && outSou |-> outLen == LEN_W'(1)); // R4

  AST_LEN_STEP: assert property (@(posedge clk) disable iff (rst)
    outValid && outReady && !outEou |=>
      !outValid || outLen == (($past(outLen) == MAXL) ? MAXL : $past(outLen) + LEN_W'(1))); // R8

  AST_HDR_FIELDS: assert property (@(posedge clk) disable iff (rst)
    outValid && outSou |-> outType == outData[4:0] && outRef == outData[6:5]); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    hdrErr |=> hdrErr); // R3

endmodule

bind nal_delimiter nal_delimiter_chk #(.LEN_W(LEN_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .outSou   (outSou),
  .outEou   (outEou),
  .outType  (outType),
  .outRef   (outRef),
  .outLen   (outLen),
  .hdrErr   (hdrErr)
);

// File: tb/nal_delimiter_bench.sv
module nal_delimiter_bench;

  localparam int LW = 4;

  typedef struct packed {
    logic [7:0]    d;
    logic          sou;
    logic          eou;
    logic [4:0]    typ;
    logic [1:0]    refi;
    logic [LW-1:0] len;
  } beat_t;

  // stimulus: {last, byte}
  localparam logic [8:0] STIM_TAB [24] = '{
    9'h055, 9'h000, 9'h000, 9'h001, 9'h061, 9'h0AA, 9'h000, 9'h0BB,
    9'h000, 9'h000, 9'h000, 9'h001, 9'h021, 9'h000, 9'h000, 9'h002,
    9'h000, 9'h001, 9'h000, 9'h000, 9'h001, 9'h085, 9'h007, 9'h100
  };

  localparam beat_t EXP_TAB [13] = '{
    '{8'h61, 1'b1, 1'b0, 5'd1, 2'd3, 4'd1},
    '{8'hAA, 1'b0, 1'b0, 5'd1, 2'd3, 4'd2},
    '{8'h00, 1'b0, 1'b0, 5'd1, 2'd3, 4'd3},
    '{8'hBB, 1'b0, 1'b1, 5'd1, 2'd3, 4'd4},
    '{8'h21, 1'b1, 1'b0, 5'd1, 2'd1, 4'd1},
    '{8'h00, 1'b0, 1'b0, 5'd1, 2'd1, 4'd2},
    '{8'h00, 1'b0, 1'b0, 5'd1, 2'd1, 4'd3},
    '{8'h02, 1'b0, 1'b0, 5'd1, 2'd1, 4'd4},
    '{8'h00, 1'b0, 1'b0, 5'd1, 2'd1, 4'd5},
    '{8'h01, 1'b0, 1'b1, 5'd1, 2'd1, 4'd6},
    '{8'h85, 1'b1, 1'b0, 5'd5, 2'd0, 4'd1},
    '{8'h07, 1'b0, 1'b0, 5'd5, 2'd0, 4'd2},
    '{8'h00, 1'b0, 1'b1, 5'd5, 2'd0, 4'd3}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [7:0] inData = '0;
  logic inValid = 1'b0, inLast = 1'b0, inReady;
  logic [7:0] outData;
  logic outValid, outSou, outEou, hdrErr;
  logic outReady = 1'b1;
  logic [4:0] outType;
  logic [1:0] outRef;
  logic [LW-1:0] outLen;

  int checks = 0, fails = 0;
  int cyc = 0;
  logic stallMode = 1'b0;
  beat_t expQ[$];

  always #5 clk = ~clk;

  nal_delimiter #(.LEN_W(LW)) u_nal_delimiter (
    .clk(clk), .rst(rst), .inData(inData), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .outData(outData), .outValid(outValid), .outReady(outReady),
    .outSou(outSou), .outEou(outEou), .outType(outType), .outRef(outRef),
    .outLen(outLen), .hdrErr(hdrErr)
  );

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic sendByte(input logic [7:0] d, input logic l);
    logic took;
    took = 1'b0;
    @(negedge clk);
    inData = d; inLast = l; inValid = 1'b1;
    while (!took) begin
      #4;
      took = inReady;
      @(posedge clk);
      if (!took) @(negedge clk);
    end
    #1;
    inValid = 1'b0; inLast = 1'b0;
  endtask

  task automatic pushBeat(input logic [7:0] d, input logic s, input logic e,
                          input logic [4:0] t, input logic [1:0] r, input logic [LW-1:0] n);
    beat_t b;
    b.d = d; b.sou = s; b.eou = e; b.typ = t; b.refi = r; b.len = n;
    expQ.push_back(b);
  endtask

  task automatic waitDrain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // ready driver and cycle counter
  initial begin
    forever begin
      @(posedge clk);
      #1;
      cyc++;
      outReady = stallMode ? (cyc % 3 != 0) : 1'b1;
    end
  end

  // output monitor
  initial begin
    logic prevStall;
    logic [7:0] prevData;
    beat_t e;
    prevStall = 1'b0;
    prevData  = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (prevStall) chk(outValid && outData == prevData, "R9 stalled beat changed", outData, prevData);
        prevStall = outValid && !outReady;
        prevData  = outData;
        if (outValid && outReady) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R6 R9 unexpected beat", outData, 0);
          end else begin
            e = expQ.pop_front();
            chk(outData == e.d && outSou == e.sou && outEou == e.eou,
                "R1 R5 R7 byte/markers", {outData, outSou, outEou}, {e.d, e.sou, e.eou});
            chk(outLen == e.len, "R4 R8 length", outLen, e.len);
            chk(outType == e.typ && outRef == e.refi, "R2 header fields",
                {outRef, outType}, {e.refi, e.typ});
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(outValid == 1'b0, "R10 outValid after reset", outValid, 0);
    chk(hdrErr == 1'b0, "R10 hdrErr after reset", hdrErr, 0);
    chk(inReady == 1'b1, "R10 inReady after reset", inReady, 1);

    // table walk: leading garbage (R6), start codes of 3 and 4 bytes (R1),
    // released zeros (R5), forbidden bit header (R3), trailing zero at end (R7)
    foreach (EXP_TAB[i]) expQ.push_back(EXP_TAB[i]);
    foreach (STIM_TAB[i]) sendByte(STIM_TAB[i][7:0], STIM_TAB[i][8]);
    waitDrain();
    chk(hdrErr == 1'b1, "R3 hdrErr raised", hdrErr, 1);

    // R6: bytes after end of stream with no start code produce nothing
    sendByte(8'h33, 1'b0);
    sendByte(8'h00, 1'b0);
    sendByte(8'h44, 1'b1);
    repeat (5) @(negedge clk);
    chk(outValid == 1'b0, "R6 no output without start code", outValid, 0);

    // R9: irregular backpressure with a released zero run and end of stream
    stallMode = 1'b1;
    pushBeat(8'h41, 1'b1, 1'b0, 5'd1, 2'd2, 4'd1);
    pushBeat(8'h11, 1'b0, 1'b0, 5'd1, 2'd2, 4'd2);
    pushBeat(8'h22, 1'b0, 1'b0, 5'd1, 2'd2, 4'd3);
    pushBeat(8'h00, 1'b0, 1'b0, 5'd1, 2'd2, 4'd4);
    pushBeat(8'h00, 1'b0, 1'b0, 5'd1, 2'd2, 4'd5);
    pushBeat(8'h00, 1'b0, 1'b0, 5'd1, 2'd2, 4'd6);
    pushBeat(8'h33, 1'b0, 1'b1, 5'd1, 2'd2, 4'd7);
    sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0); sendByte(8'h01, 1'b0);
    sendByte(8'h41, 1'b0); sendByte(8'h11, 1'b0); sendByte(8'h22, 1'b0);
    sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0);
    sendByte(8'h33, 1'b1);
    waitDrain();
    stallMode = 1'b0;

    // R8: length saturates at 15 with LEN_W = 4
    pushBeat(8'h05, 1'b1, 1'b0, 5'd5, 2'd0, 4'd1);
    for (int k = 2; k <= 19; k++)
      pushBeat(8'h10, 1'b0, (k == 19), 5'd5, 2'd0, (k > 15) ? 4'd15 : LW'(k));
    sendByte(8'h00, 1'b0); sendByte(8'h00, 1'b0); sendByte(8'h01, 1'b0);
    sendByte(8'h05, 1'b0);
    for (int k = 2; k <= 19; k++) sendByte(8'h10, (k == 19));
    waitDrain();
    chk(hdrErr == 1'b1, "R3 hdrErr still set", hdrErr, 1);
    chk(expQ.size() == 0, "R9 all expected beats seen", expQ.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule